// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM with 8192 bytes behind 13 address lines and an 8-bit shared data bus. The host posts one request at a time: an address, a write byte and a direction flag. The controller then runs a complete memory cycle in three timed phases. First it presents the address with the memory deselected. Then it selects the memory and, for a write, lowers the write enable. Last it deselects again while holding the address. After the cycle it reports completion with a one-cycle done pulse. For a read, the returned byte comes with that pulse.

The shared bus is split into three ports: the byte the controller would drive, the driver enable and the byte seen on the pins. Board-level tristate buffers are wired from these. The controller turns its drivers on only while the write strobe is active. The memory drives the bus only while output enable is low, and the controller keeps output enable high for every write. The two therefore never drive the bus together. Address and write data come from registers that are loaded once per request, so they cannot move while the memory is writing. Phase lengths are parameters, each at least one clock cycle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, both chip selects are inactive (active-low select high, active-high select low), write enable and output enable are high, the bus driver enable is low, done is low and req_ready is high.
- R2: req_ready is high only while no cycle is in progress. A request is accepted on a clock edge where req_valid and req_ready are both high.
- R3: An accepted request is followed by SETUP_CYC cycles with the address presented and the memory deselected, then STROBE_CYC cycles with the memory selected, then HOLD_CYC cycles deselected. Done is high in the cycle after the last hold cycle, which is SETUP_CYC+STROBE_CYC+HOLD_CYC cycles after the accepting edge.
- R4: In a write, write enable is low for exactly the strobe cycles and output enable stays high. The bus driver enable is high only in cycles where write enable is also low.
- R5: The address and the driven write byte do not change while the memory is selected with write enable low. The address is also unchanged in the first cycle of selection and in the first cycle after deselection.
- R6: In a read, output enable is low for exactly the strobe cycles, write enable stays high and the drivers stay off. rd_data takes the bus value of the last strobe cycle and holds it until the next read.
- R7: done is high for exactly one cycle per cycle run.
- R8: The bus driver enable is never high while output enable is low.
- R9: A read of any address returns the byte last written to it, at addresses from 0 to 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, a request can be accepted |
| rd_data | output | 8 | Byte from the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 13 | Memory address lines |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| bus_dout | output | 8 | Byte driven onto the shared bus |
| bus_oe | output | 1 | Enable for the bus drivers |
| bus_din | input | 8 | Byte seen on the shared bus |

## Verification
The assertions assume that the host starts a new request only while req_ready is high. They also assume that bus_din carries the memory's output during read strobes. The bench keeps within these limits by issuing each request from a task that waits for done before it returns. Its memory model drives the bus only while the memory is selected, write enable is high and output enable is low, and it drives zero otherwise. The sweep writes a computed byte to 1024 addresses spread over the whole 13-bit space, with both ends included, and then reads each one back.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int SETUP_CYC = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, HOLD} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic          strobe;

  initial begin
    assert (SETUP_CYC >= 1 && STROBE_CYC >= 1 && HOLD_CYC >= 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          ph      <= SETUP;
          cnt     <= CW'(SETUP_CYC - 1);
        end
        SETUP: if (cnt == '0) begin
          ph  <= STROBE;
          cnt <= CW'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        STROBE: if (cnt == '0) begin
          if (!wr_q) rd_data <= bus_din;
          ph  <= HOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          ph   <= IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign strobe    = (ph == STROBE);
  assign req_ready = (ph == IDLE);
  assign mem_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign mem_cs_n  = !strobe;
  assign mem_cs    = strobe;
  assign mem_we_n  = !(strobe && wr_q);
  assign mem_oe_n  = !(strobe && !wr_q);
  assign bus_oe    = strobe && wr_q;

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  // R4
  drive_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!mem_we_n && !mem_cs_n));
  // R5
  write_window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_we_n) |=> ((mem_cs_n || mem_we_n) || ($stable(mem_addr) && $stable(bus_dout))));
  // R5
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> $stable(mem_addr));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $stable(mem_addr));
  // R6
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n && $past(mem_cs_n)) |-> $stable(rd_data));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!bus_oe && mem_we_n));
endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  localparam int S = 1, T = 2, H = 1;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, done, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, bus_oe;
  logic [7:0] rd_data, bus_dout, bus_din;
  logic [12:0] mem_addr;
  logic [7:0] mem [0:1023];
  int total = 0, bad = 0, clash = 0;

  always #2 clk = ~clk;

  sram_cycle_ctrl #(.SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H)) i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .done(done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din));

  wire sel = !mem_cs_n && mem_cs;
  assign bus_din = (sel && mem_we_n && !mem_oe_n) ? mem[mem_addr[12:3]] : 8'h00;

  always @(posedge clk)
    if (sel && !mem_we_n) mem[mem_addr[12:3]] <= bus_oe ? bus_dout : 8'hxx;

  always @(negedge clk)
    if (rst_n && ((sel && mem_we_n && !mem_oe_n && bus_oe) || (bus_oe && mem_we_n))) clash++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] addr_of(int i);
    return 13'(i * 8 + (i >> 7));
  endfunction

  function automatic logic [7:0] data_of(int i);
    return 8'((i * 29 + (i >> 3)) ^ 8'h5A);
  endfunction

  task automatic xfer(input bit wr, input logic [12:0] a, input logic [7:0] d, output logic [7:0] rd);
    int k, nstr, nset, nwe, noe, busy_rdy;
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    k = 0; nstr = 0; nset = 0; nwe = 0; noe = 0; busy_rdy = 0; seen = 0;
    while (!done && k < 50) begin
      if (!mem_cs_n) begin nstr++; seen = 1; end
      else if (!seen) nset++;
      if (!mem_we_n) nwe++;
      if (!mem_oe_n) noe++;
      if (req_ready) busy_rdy++;
      k++;
      @(negedge clk);
    end
    chk(k == S + T + H, "R3 latency", k, S + T + H);
    chk(nset == S && nstr == T, "R3 phases", nset * 100 + nstr, S * 100 + T);
    chk(busy_rdy == 0, "R2 ready while busy", busy_rdy, 0);
    if (wr) chk(nwe == T && noe == 0, "R4 write strobes", nwe * 100 + noe, T * 100);
    else chk(noe == T && nwe == 0, "R6 read strobes", noe * 100 + nwe, T * 100);
    chk(req_ready, "R2 ready at done", req_ready, 1);
    rd = rd_data;
    @(negedge clk);
    chk(!done, "R7 done width", done, 0);
    chk(rd_data == rd, "R6 rd_data held", rd_data, rd);
  endtask

  initial begin
    logic [7:0] r;
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #1;
    chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !bus_oe && !done && req_ready,
        "R1 reset state", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, bus_oe, done, req_ready}, 7'b1011001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done, "R1 after release", {req_ready, done}, 2'b10);
    for (int i = 0; i < 1024; i++) xfer(1'b1, addr_of(i), data_of(i), r);
    for (int i = 0; i < 1024; i++) begin
      xfer(1'b0, addr_of(i), 8'h00, r);
      chk(r == data_of(i), "R9 readback", r, data_of(i));
    end
    xfer(1'b1, 13'h1FFF, 8'hC3, r);
    xfer(1'b0, 13'h0000, 8'h00, r);
    chk(r == data_of(0), "R9 low end", r, data_of(0));
    xfer(1'b0, 13'h1FFF, 8'h00, r);
    chk(r == 8'hC3, "R9 high end", r, 8'hC3);
    xfer(1'b1, 13'h0008, 8'h11, r);
    chk(rd_data == 8'hC3, "R6 write keeps rd_data", rd_data, 8'hC3);
    chk(clash == 0, "R8 bus contention", clash, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule